// File: doc/BRIEF.md
# Block Cipher Register Front-End

This block sits between a 32-bit register bus and a 128-bit block cipher core. Software or a DMA engine writes the key, an initial chaining value and a mode word. Plaintext or ciphertext then enters through a window of four data registers. Once a full block has arrived, the front-end applies cipher-block chaining where it is selected and starts the core through a start/done handshake. It holds the result in an output buffer, where four data reads collect it.

Two request lines drive an external DMA controller. One request moves a whole 128-bit block, either into the input window or out of the output window. A single start bit gates every data movement. A self-clearing soft reset returns every register to its reset value. The core itself is outside the block and is reached only through its port.

Top module: `cipher_regfront`

## Requirements
- R1: After reset the registers read as follows:
  - control (byte 0x30) reads 0x02;
  - the configuration word (byte 0x48) reads 0;
  - the status word (byte 0x4C) reads 1;
  - the revision word (byte 0x44) reads {major, minor} in bits 7:4 and 3:0 (defaults 2 and 1);
  - both DMA request lines are low.
- R2: Key word x (x = 0..7) is read and written at byte address 0x1C − 4·(x XOR 1). It drives bits 32x+31:32x of `core_key`.
- R3: With chaining off, the core input is the written block and the output buffer receives the core output unchanged. Data word i occupies bits 32i+31:32i and sits at byte 0x34 + 4i. Control bit 2 drives `core_enc`, where 1 means encrypt. Bits 4:3 drive `core_ksz`.
- R4: With control bit 5 set and encrypt selected, the core input is the plaintext XOR the chaining value. The core output is both the result and the next chaining value.
- R5: With control bit 5 set and decrypt selected, the result is the core output XOR the chaining value. The incoming ciphertext becomes the next chaining value.
- R6: The four chaining words at bytes 0x20–0x2C can be written, and they read back the current chaining value, with word i in bits 32i+31:32i.
- R7: `core_start` is raised for exactly one cycle, in the cycle after the fourth data write of a block. Control bit 1 (input-ready) then reads 0 until the core reports done.
- R8: `dma_in_req` is high when start (configuration bit 5), DMA-in enable (bit 2) and an empty input buffer all hold. It falls after the fourth data write.
- R9: `dma_out_req` is high when start, DMA-out enable (bit 3) and control bit 0 (output-ready) all hold. A read of data word 3 clears output-ready and frees the output buffer.
- R10: While start is 0, no block is started and neither request line rises, even with a full input buffer.
- R11: Writing 1 to configuration bit 1 resets every register on the next clock. In the cycle in between, status bit 0 reads 0 and bit 1 reads 1. After it, status reads 1 and bit 1 reads 0.
- R12: Control bits 7 and 6 are stored and read back but do not change any result.
- R13: A fourth input write and a read of data word 3 in the same cycle are both honoured. The old word 3 is returned, and the new block starts on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 8 | Write byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (read side effects on the edge) |
| bus_raddr | input | 8 | Read byte address (word aligned) |
| bus_rdata | output | 32 | Read data, combinational from `bus_raddr` |
| core_start | output | 1 | One-cycle launch pulse to the core |
| core_key | output | 256 | Eight key words |
| core_ksz | output | 2 | Key size code |
| core_enc | output | 1 | 1 = encrypt |
| core_din | output | 128 | Block to the core, held while it runs |
| core_done | input | 1 | Core result valid |
| core_dout | input | 128 | Core result |
| dma_in_req | output | 1 | Request for one input block |
| dma_out_req | output | 1 | Request to drain one output block |

## Verification
Two things can land on the same clock edge: the last write of a new input block, and the read of data word 3 that releases the previous result. The bench provokes this with the output buffer full. It writes three words of the next block, drains three words of the old result, then issues the fourth write and the final read together on the separate write and read ports. It judges the outcome on three points. The read must return the old word. Both request lines must drop. `core_start` must rise in the very next cycle, and the new block's result must then match the scoreboard.

// File: rtl/crf_pkg.sv
// Shared constants for the cipher register front-end.
// Word indices are byte address / 4; the block assumes four data words.
package crf_pkg;
    localparam logic [5:0] W_IV0   = 6'd8;
    localparam logic [5:0] W_CTRL  = 6'd12;
    localparam logic [5:0] W_DATA0 = 6'd13;
    localparam logic [5:0] W_REV   = 6'd17;
    localparam logic [5:0] W_MASK  = 6'd18;
    localparam logic [5:0] W_STAT  = 6'd19;

    localparam int MB_SRST = 1;

    // Stored mode fields of the control word.
    typedef struct packed {
        logic       ctr_w;
        logic       ctr;
        logic       cbc;
        logic [1:0] ksz;
        logic       dir;
    } ctrl_t;

    // Stored fields of the configuration word.
    typedef struct packed {
        logic sidle;
        logic start;
        logic dout_en;
        logic din_en;
        logic autoidle;
    } cfg_t;
endpackage

// File: rtl/crf_regfile.sv
// Key, control and configuration storage.
// Assumes NKEY is a power of two; key slots are pair-swapped in descending order.
module crf_regfile
    import crf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NKEY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [5:0]       wr_word,
    input  logic [DW-1:0]    wr_data,
    input  logic [5:0]       rd_word,
    output logic [DW-1:0]    key_rdata,
    output logic [NKEY*DW-1:0] key_flat,
    output ctrl_t            ctrl,
    output cfg_t             cfg
);
    localparam int KIW = $clog2(NKEY);
    localparam logic [5:0] NKEY_W = 6'(NKEY);

    logic           key_hit;
    logic [KIW-1:0] wslot;
    logic [KIW-1:0] rslot;

    // Map word index to key slot: slot = (NKEY-1 - word) XOR 1.
    assign key_hit = wr_en && (wr_word < NKEY_W);
    assign wslot   = (KIW'(NKEY - 1) - wr_word[KIW-1:0]) ^ KIW'(1);
    assign rslot   = (KIW'(NKEY - 1) - rd_word[KIW-1:0]) ^ KIW'(1);

    for (genvar x = 0; x < NKEY; x++) begin : g_key
        logic [DW-1:0] kq;
        // Hold one key word until rewritten or reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                kq <= '0;
            else if (key_hit && wslot == KIW'(x))
                kq <= wr_data;
        end
        assign key_flat[x*DW +: DW] = kq;
    end

    // Key readback through the same slot mapping.
    assign key_rdata = key_flat[rslot*DW +: DW];

    // Control word mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && wr_word == W_CTRL)
            ctrl <= '{ctr_w: wr_data[7], ctr: wr_data[6], cbc: wr_data[5],
                      ksz: wr_data[4:3], dir: wr_data[2]};
    end

    // Configuration word fields (soft reset is handled at the top).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr_en && wr_word == W_MASK)
            cfg <= '{sidle: wr_data[6], start: wr_data[5], dout_en: wr_data[3],
                     din_en: wr_data[2], autoidle: wr_data[0]};
    end
endmodule

// File: rtl/crf_blockpath.sv
// Input/output block buffers, chaining value and core handshake.
// Assumes the core holds done for one cycle per start and reads core_din
// while running. The input buffer is held until done; launch waits for a
// free output buffer.
module crf_blockpath
    import crf_pkg::*;
#(
    parameter int DW = 32,
    parameter int NW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cbc,
    input  logic             enc,
    input  logic             wr_en,
    input  logic [5:0]       wr_word,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [5:0]       rd_word,
    output logic             core_start,
    output logic [NW*DW-1:0] core_din,
    input  logic             core_done,
    input  logic [NW*DW-1:0] core_dout,
    output logic             in_full,
    output logic             out_full,
    output logic [DW-1:0]    data_rdata,
    output logic [DW-1:0]    iv_rdata
);
    localparam int BW = NW * DW;
    localparam int IW = $clog2(NW);
    localparam logic [5:0] D_END  = W_DATA0 + 6'(NW);
    localparam logic [5:0] IV_END = W_IV0 + 6'(NW);

    logic [BW-1:0] in_blk, out_blk, chain, result, next_chain;
    logic [IW-1:0] in_cnt, wr_didx, wr_iidx, rd_didx, rd_iidx;
    logic          busy, data_hit, iv_hit, last_rd, done_hit;

    assign data_hit = wr_en && wr_word >= W_DATA0 && wr_word < D_END;
    assign iv_hit   = wr_en && wr_word >= W_IV0 && wr_word < IV_END;
    assign last_rd  = rd_en && rd_word == D_END - 6'd1;
    assign wr_didx  = IW'(wr_word - W_DATA0);
    assign wr_iidx  = IW'(wr_word - W_IV0);
    assign rd_didx  = IW'(rd_word - W_DATA0);
    assign rd_iidx  = IW'(rd_word - W_IV0);
    assign done_hit = core_done && busy;

    // Launch when a full block waits, the core is idle and the output is free.
    assign core_start = in_full && !busy && run && !out_full;
    assign core_din   = (cbc && enc) ? (in_blk ^ chain) : in_blk;
    assign result     = (cbc && !enc) ? (core_dout ^ chain) : core_dout;
    assign next_chain = enc ? core_dout : in_blk;

    // Collect input words; the fourth marks the buffer full until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_blk  <= '0;
            in_cnt  <= '0;
            in_full <= 1'b0;
        end else if (done_hit) begin
            in_full <= 1'b0;
        end else if (data_hit && !in_full) begin
            in_blk[wr_didx*DW +: DW] <= wr_data;
            if (in_cnt == IW'(NW - 1)) begin
                in_cnt  <= '0;
                in_full <= 1'b1;
            end else begin
                in_cnt <= in_cnt + 1'b1;
            end
        end
    end

    // Track whether the core is working on a block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (core_start)
            busy <= 1'b1;
        else if (done_hit)
            busy <= 1'b0;
    end

    // Capture results; reading the last data word frees the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_blk  <= '0;
            out_full <= 1'b0;
        end else if (done_hit) begin
            out_blk  <= result;
            out_full <= 1'b1;
        end else if (last_rd && out_full) begin
            out_full <= 1'b0;
        end
    end

    // Chaining value: updated by a finished block, else by a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else if (done_hit && cbc)
            chain <= next_chain;
        else if (iv_hit)
            chain[wr_iidx*DW +: DW] <= wr_data;
    end

    assign data_rdata = out_blk[rd_didx*DW +: DW];
    assign iv_rdata   = chain[rd_iidx*DW +: DW];
endmodule

// File: rtl/crf_dmareq.sv
// DMA request generation for one block in and one block out.
// Assumes buffer flags are registered, so the requests are glitch-free.
module crf_dmareq (
    input  logic run,
    input  logic din_en,
    input  logic dout_en,
    input  logic in_full,
    input  logic out_full,
    output logic dma_in_req,
    output logic dma_out_req
);
    // Request input while the input buffer is empty, output while a result waits.
    always_comb begin
        dma_in_req  = run && din_en && !in_full;
        dma_out_req = run && dout_en && out_full;
    end
endmodule

// File: rtl/cipher_regfront.sv
// Register front-end for a 128-bit block cipher core.
// Assumes word-aligned byte addresses (unaligned accesses are ignored),
// DW >= 8, and a register map laid out for four data words.
module cipher_regfront
    import crf_pkg::*;
#(
    parameter int         DW        = 32,
    parameter int         NKEY      = 8,
    parameter int         NW        = 4,
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [7:0]         bus_waddr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic               bus_rd,
    input  logic [7:0]         bus_raddr,
    output logic [DW-1:0]      bus_rdata,
    output logic               core_start,
    output logic [NKEY*DW-1:0] core_key,
    output logic [1:0]         core_ksz,
    output logic               core_enc,
    output logic [NW*DW-1:0]   core_din,
    input  logic               core_done,
    input  logic [NW*DW-1:0]   core_dout,
    output logic               dma_in_req,
    output logic               dma_out_req
);
    localparam logic [5:0] NKEY_W = 6'(NKEY);
    localparam logic [5:0] D_END  = W_DATA0 + 6'(NW);
    localparam logic [5:0] IV_END = W_IV0 + 6'(NW);

    logic       wr_go, rd_go, srst_q, blk_rst_n, run_en, in_full, out_full;
    logic [5:0] wr_word, rd_word;
    logic [DW-1:0] key_rdata, data_rdata, iv_rdata;
    ctrl_t ctrl;
    cfg_t  cfg;

    assign wr_go     = bus_wr && bus_waddr[1:0] == 2'b00;
    assign rd_go     = bus_rd && bus_raddr[1:0] == 2'b00;
    assign wr_word   = bus_waddr[7:2];
    assign rd_word   = bus_raddr[7:2];
    assign blk_rst_n = rst_n && !srst_q;
    assign run_en    = cfg.start;

    // One-cycle soft reset request, cleared by the reset it causes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            srst_q <= 1'b0;
        else
            srst_q <= wr_go && wr_word == W_MASK && bus_wdata[MB_SRST] && !srst_q;
    end

    crf_regfile #(.DW(DW), .NKEY(NKEY)) u_regs (
        .clk(clk), .rst_n(blk_rst_n), .wr_en(wr_go), .wr_word(wr_word),
        .wr_data(bus_wdata), .rd_word(rd_word), .key_rdata(key_rdata),
        .key_flat(core_key), .ctrl(ctrl), .cfg(cfg)
    );

    crf_blockpath #(.DW(DW), .NW(NW)) u_path (
        .clk(clk), .rst_n(blk_rst_n), .run(run_en), .cbc(ctrl.cbc), .enc(ctrl.dir),
        .wr_en(wr_go), .wr_word(wr_word), .wr_data(bus_wdata),
        .rd_en(rd_go), .rd_word(rd_word), .core_start(core_start),
        .core_din(core_din), .core_done(core_done), .core_dout(core_dout),
        .in_full(in_full), .out_full(out_full),
        .data_rdata(data_rdata), .iv_rdata(iv_rdata)
    );

    crf_dmareq u_dma (
        .run(run_en), .din_en(cfg.din_en), .dout_en(cfg.dout_en),
        .in_full(in_full), .out_full(out_full),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    assign core_ksz = ctrl.ksz;
    assign core_enc = ctrl.dir;

    // Read multiplexer over the register map.
    always_comb begin
        bus_rdata = '0;
        if (rd_word < NKEY_W)
            bus_rdata = key_rdata;
        else if (rd_word >= W_IV0 && rd_word < IV_END)
            bus_rdata = iv_rdata;
        else if (rd_word == W_CTRL)
            bus_rdata[7:0] = {ctrl.ctr_w, ctrl.ctr, ctrl.cbc, ctrl.ksz, ctrl.dir,
                              !in_full, out_full};
        else if (rd_word >= W_DATA0 && rd_word < D_END)
            bus_rdata = data_rdata;
        else if (rd_word == W_REV)
            bus_rdata[7:0] = {REV_MAJOR, REV_MINOR};
        else if (rd_word == W_MASK)
            bus_rdata[7:0] = {1'b0, cfg.sidle, cfg.start, 1'b0, cfg.dout_en,
                              cfg.din_en, srst_q, cfg.autoidle};
        else if (rd_word == W_STAT)
            bus_rdata[0] = !srst_q;
    end
endmodule

// File: rtl/crf_checker.sv
// Temporal checks on the front-end, bound into every cipher_regfront.
// Assumes run_en is the stored start bit of the configuration word.
module crf_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [7:0]    bus_waddr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_rd,
    input logic [7:0]    bus_raddr,
    input logic          core_start,
    input logic          dma_in_req,
    input logic          dma_out_req,
    input logic          run_en
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);                                          // R7
    AST_FULL_NO_INREQ: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !dma_in_req);                                          // R8
    AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_out_req && bus_rd && bus_raddr == 8'h40) |=> !dma_out_req);      // R9
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !(dma_in_req || dma_out_req || core_start));              // R10
    AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_waddr == 8'h48 && bus_wdata[1]) |=> ##1
        (!dma_in_req && !dma_out_req && !run_en));                            // R11
endmodule

bind cipher_regfront crf_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_raddr(bus_raddr),
    .core_start(core_start), .dma_in_req(dma_in_req),
    .dma_out_req(dma_out_req), .run_en(run_en)
);

// File: tb/cipher_regfront_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes predicted blocks, monitor drains and compares.
module cipher_regfront_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic         bus_wr = 1'b0, drv_rd = 1'b0, mon_rd = 1'b0, mon_en = 1'b0;
    logic [7:0]   bus_waddr = '0, drv_raddr = '0, mon_raddr = '0;
    logic [31:0]  bus_wdata = '0, bus_rdata;
    logic         bus_rd;
    logic [7:0]   bus_raddr;
    logic         core_start, core_enc, core_done, dma_in_req, dma_out_req;
    logic [255:0] core_key;
    logic [1:0]   core_ksz;
    logic [127:0] core_din, core_dout;

    assign bus_rd    = drv_rd | mon_rd;
    assign bus_raddr = mon_rd ? mon_raddr : drv_raddr;

    int n_checks = 0, n_err = 0, n_start = 0;
    logic [127:0] exp_q[$];
    string        tag_q[$];
    logic         m_cbc = 1'b0, m_enc = 1'b1;
    logic [127:0] chain_m = '0;
    logic [31:0]  kw[8];

    function automatic logic [127:0] sc_enc(logic [127:0] x, logic [127:0] k);
        logic [127:0] t;
        t = x ^ k;
        return {t[119:0], t[127:120]};
    endfunction

    function automatic logic [127:0] sc_dec(logic [127:0] x, logic [127:0] k);
        return {x[7:0], x[127:8]} ^ k;
    endfunction

    cipher_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_raddr(bus_raddr),
        .bus_rdata(bus_rdata), .core_start(core_start), .core_key(core_key),
        .core_ksz(core_ksz), .core_enc(core_enc), .core_din(core_din),
        .core_done(core_done), .core_dout(core_dout),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    // Behavioural stand-in for the cipher core, three cycles of latency.
    logic [127:0] sb_din = '0;
    logic         sb_enc = 1'b0;
    int           sb_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) sb_cnt <= 0;
        else if (core_start) begin
            sb_cnt <= 3; sb_din <= core_din; sb_enc <= core_enc;
            n_start <= n_start + 1;
        end else if (sb_cnt != 0) sb_cnt <= sb_cnt - 1;
    end
    assign core_done = (sb_cnt == 1);
    assign core_dout = sb_enc ? sc_enc(sb_din, core_key[127:0])
                              : sc_dec(sb_din, core_key[127:0]);

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        drv_rd = 1'b1; drv_raddr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        drv_rd = 1'b0;
    endtask

    function automatic logic [127:0] predict(logic [127:0] p);
        logic [127:0] k, e;
        k = {kw[3], kw[2], kw[1], kw[0]};
        if (!m_cbc) e = m_enc ? sc_enc(p, k) : sc_dec(p, k);
        else if (m_enc) begin e = sc_enc(p ^ chain_m, k); chain_m = e; end
        else begin e = sc_dec(p, k) ^ chain_m; chain_m = p; end
        return e;
    endfunction

    // Driver: predict, queue, then feed one block on the input request.
    task automatic send_block(input logic [127:0] p, input string tag);
        exp_q.push_back(predict(p));
        tag_q.push_back(tag);
        while (!dma_in_req) @(negedge clk);
        for (int i = 0; i < 4; i++) wr(8'h34 + 8'(4 * i), p[32*i +: 32]);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: on an output request, read four words and compare.
    initial begin
        logic [127:0] got;
        forever begin
            @(negedge clk);
            if (mon_en && dma_out_req) begin
                for (int i = 0; i < 4; i++) begin
                    mon_rd = 1'b1; mon_raddr = 8'h34 + 8'(4 * i);
                    #1 got[32*i +: 32] = bus_rdata;
                    @(negedge clk);
                end
                mon_rd = 1'b0;
                if (exp_q.size() == 0) check(1'b0, "R9 unexpected block", got, '0);
                else check(got == exp_q[0], tag_q[0], got, exp_q[0]);
                if (exp_q.size() != 0) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    bit done_flag = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_err++; n_checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0]  d;
        logic [127:0] pa, pb, ea, eb, iv0, got;
        int           s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h30, d); check(d == 32'h2, "R1 ctrl", d, 32'h2);
        rd(8'h48, d); check(d == 32'h0, "R1 mask", d, 0);
        rd(8'h4C, d); check(d == 32'h1, "R1 status", d, 1);
        rd(8'h44, d); check(d == 32'h21, "R1 revision", d, 32'h21);
        check(!dma_in_req && !dma_out_req, "R1 requests", {dma_in_req, dma_out_req}, 0);

        // R2 key placement
        for (int x = 0; x < 8; x++) begin
            kw[x] = 32'hA5A5_0000 + 32'(x) * 32'h0101_0101 + 32'h0F;
            wr(8'h1C - 8'(4 * (x ^ 1)), kw[x]);
        end
        for (int x = 0; x < 8; x++) begin
            rd(8'h1C - 8'(4 * (x ^ 1)), d);
            check(d == kw[x], "R2 key readback", d, kw[x]);
            check(core_key[32*x +: 32] == kw[x], "R2 key port", core_key[32*x +: 32], kw[x]);
        end

        // R12 counter bits stored; R3 direction/size to core
        wr(8'h30, 32'hCC);
        rd(8'h30, d); check(d == 32'hCE, "R12 ctrl readback", d, 32'hCE);
        check(core_enc == 1'b1 && core_ksz == 2'b01, "R3 core mode", {core_enc, core_ksz}, 3'b101);

        // R10 start gating with a full input buffer
        wr(8'h48, 32'h0C);
        check(!dma_in_req, "R10 no input request", dma_in_req, 0);
        m_cbc = 1'b0; m_enc = 1'b1;
        pa = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
        exp_q.push_back(predict(pa)); tag_q.push_back("R12 ECB with counter bits");
        for (int i = 0; i < 4; i++) wr(8'h34 + 8'(4 * i), pa[32*i +: 32]);
        repeat (8) @(negedge clk);
        check(n_start == 0, "R10 no launch", n_start, 0);
        rd(8'h30, d); check(d == 32'hCC, "R7 input-ready low while held", d, 32'hCC);
        mon_en = 1'b1;
        wr(8'h48, 32'h2C);
        drain();

        // R3 ECB encrypt and decrypt streams
        wr(8'h30, 32'h0C);
        for (int b = 0; b < 3; b++) send_block({4{32'hC0DE_0000 + 32'(b)}} ^ 128'(b * 977), "R3 ECB encrypt");
        drain();
        wr(8'h30, 32'h08); m_enc = 1'b0;
        for (int b = 0; b < 2; b++) send_block({4{32'h1234_5678}} + 128'(b), "R3 ECB decrypt");
        drain();

        // R4 CBC encrypt, R6 chaining readback
        iv0 = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
        for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4 * i), iv0[32*i +: 32]);
        chain_m = iv0; m_cbc = 1'b1; m_enc = 1'b1;
        wr(8'h30, 32'h2C);
        for (int b = 0; b < 3; b++) send_block({4{32'hBEEF_0000}} + 128'(b), "R4 CBC encrypt");
        drain();
        mon_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rd(8'h20 + 8'(4 * i), d);
            check(d == chain_m[32*i +: 32], "R6 chain after encrypt", d, chain_m[32*i +: 32]);
        end

        // R5 CBC decrypt, R6 again
        for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4 * i), iv0[32*i +: 32]);
        chain_m = iv0; m_enc = 1'b0; mon_en = 1'b1;
        wr(8'h30, 32'h28);
        for (int b = 0; b < 3; b++) send_block({4{32'h7777_0000}} ^ 128'(b * 31), "R5 CBC decrypt");
        drain();
        mon_en = 1'b0;
        rd(8'h2C, d); check(d == chain_m[127:96], "R6 chain after decrypt", d, chain_m[127:96]);

        // R9, R8, R13 overlap of the last write and the last read
        wr(8'h30, 32'h0C); m_cbc = 1'b0; m_enc = 1'b1;
        pa = 128'hAAAA_BBBB_CCCC_DDDD_1111_2222_3333_4444;
        pb = 128'h5555_6666_7777_8888_9999_0000_EEEE_FFFF;
        ea = predict(pa); eb = predict(pb);
        while (!dma_in_req) @(negedge clk);
        for (int i = 0; i < 4; i++) wr(8'h34 + 8'(4 * i), pa[32*i +: 32]);
        rd(8'h30, d); check(d[1] == 1'b0, "R7 input-ready after fourth word", d[1], 0);
        d = 0;
        while (!d[0]) rd(8'h30, d);
        check(dma_out_req == 1'b1, "R9 output request", dma_out_req, 1);
        check(dma_in_req == 1'b1, "R8 input request on empty buffer", dma_in_req, 1);
        for (int i = 0; i < 3; i++) wr(8'h34 + 8'(4 * i), pb[32*i +: 32]);
        for (int i = 0; i < 3; i++) begin
            rd(8'h34 + 8'(4 * i), d);
            check(d == ea[32*i +: 32], "R9 first result word", d, ea[32*i +: 32]);
        end
        s0 = n_start;
        bus_wr = 1'b1; bus_waddr = 8'h40; bus_wdata = pb[127:96];
        drv_rd = 1'b1; drv_raddr = 8'h40;
        #1 got[31:0] = bus_rdata;
        @(negedge clk);
        bus_wr = 1'b0; drv_rd = 1'b0;
        check(got[31:0] == ea[127:96], "R13 old word 3 returned", got[31:0], ea[127:96]);
        check(!dma_in_req && !dma_out_req, "R8 R9 requests drop", {dma_in_req, dma_out_req}, 0);
        check(core_start == 1'b1, "R13 launch next clock", core_start, 1);
        @(negedge clk);
        check(n_start == s0 + 1, "R7 single start pulse", n_start, s0 + 1);
        d = 0;
        while (!d[0]) rd(8'h30, d);
        for (int i = 0; i < 4; i++) begin
            rd(8'h34 + 8'(4 * i), d);
            got[32*i +: 32] = d;
        end
        check(got == eb, "R13 second block", got, eb);

        // R11 soft reset
        wr(8'h48, 32'h2E);
        rd(8'h4C, d); check(d == 32'h0, "R11 status during reset", d, 0);
        rd(8'h48, d); check(d == 32'h0, "R11 mask cleared", d, 0);
        rd(8'h4C, d); check(d == 32'h1, "R11 reset done", d, 1);
        rd(8'h30, d); check(d == 32'h2, "R11 ctrl cleared", d, 2);
        rd(8'h1C, d); check(d == 32'h0, "R11 key cleared", d, 0);
        rd(8'h20, d); check(d == 32'h0, "R11 chain cleared", d, 0);
        check(!dma_in_req && !dma_out_req, "R11 requests low", {dma_in_req, dma_out_req}, 0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule